// File: doc/BRIEF.md
# Serial Audio Input Port

This block takes two-channel audio arriving over three wires (a frame clock that marks which channel is being sent, a bit clock, and one serial data line) and delivers each frame as a parallel left word and a parallel right word, flagged by a single-cycle valid strobe in the system master clock domain. Words are presented as 24 bits, aligned to the top of the bus, with any unused low bits cleared.

One shift engine covers the common formats through four settings: where the word sits in its half frame (starting at the frame-clock edge or ending at it), whether the first data bit lags the frame-clock edge by one bit clock, which bit-clock edge samples data, and which frame-clock level means the left channel. An I²S-style link, a left-justified link and a right-justified link are therefore only different control values. In left-aligned settings the word length is set by the number of bit clocks in each half frame.

The port can either follow an external bit clock and frame clock (slave role) or produce both from the master clock with a programmable divider and a programmable count of bit clocks per half frame (master role). In slave role the bit clock may be asynchronous to the master clock and may pause, and the two halves of a frame need not be equal in length.

Top module: `audin_top`

## Requirements
- R1: While reset is asserted and right after its release, leftSample and rightSample are 0 and sampleValid is low.
- R2: With rightJust=0 and firstDelay=0, the word in each half frame starts at the first bit sampled after the frame clock changes and is received MSB first; a word shorter than 24 bits appears in bits 23 down, with the remaining low bits 0.
- R3: With rightJust=0, a half frame carrying more than 24 bits yields its first 24 bits; later bits are dropped.
- R4: With firstDelay=1 the bit sampled at a frame-clock change is not part of the new word, which starts one bit clock later (it still belongs to the word just ending); lrPol=1 makes a low frame clock mean the left channel, lrPol=0 a high one.
- R5: With rightJust=1, the word ends with the last bit sampled before the frame clock changes; resSel 00 and 11 take 24 bits, 01 takes 20 bits, 10 takes 16 bits; earlier bits in the half frame are ignored and the word is placed at bits 23 down with low bits 0.
- R6: bclkPol=0 samples data and frame clock on the rising bit-clock edge, bclkPol=1 on the falling edge.
- R7: sampleValid is a one-master-clock pulse issued once per frame after the right word completes; leftSample and rightSample change only in a cycle where sampleValid is high.
- R8: After reset no valid is issued until a left word that began after a frame-clock change and the right word following it have both completed.
- R9: In master role (masterMode=1) bclkOut has a period of 2*(mclkDiv+1) master clocks, each frame-clock half holds halfBits sampling edges, and lrclkOut changes only together with a non-sampling bit-clock edge.
- R10: In slave role (masterMode=0) bclkOut and lrclkOut are held at 0 and bclkIn and lrclkIn clock the receiver.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | System master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| masterMode | input | 1 | 1: generate bit and frame clocks; 0: follow external clocks |
| resSel | input | 2 | Word width for right-aligned data (00/11: 24, 01: 20, 10: 16) |
| rightJust | input | 1 | 1: word ends at the frame-clock edge; 0: word starts there |
| firstDelay | input | 1 | 1: first data bit lags the frame-clock edge by one bit clock |
| bclkPol | input | 1 | 0: sample on rising bit-clock edge; 1: on falling edge |
| lrPol | input | 1 | 0: frame clock high means left; 1: low means left |
| mclkDiv | input | DIV_W | Master-role bit-clock half period in master clocks, minus one |
| halfBits | input | HB_W | Master-role sampling edges per half frame |
| bclkIn | input | 1 | External bit clock (slave role) |
| lrclkIn | input | 1 | External frame clock (slave role) |
| sdin | input | 1 | Serial data, MSB first |
| bclkOut | output | 1 | Generated bit clock (0 in slave role) |
| lrclkOut | output | 1 | Generated frame clock (0 in slave role) |
| leftSample | output | 24 | Last completed left word, MSB aligned |
| rightSample | output | 24 | Last completed right word, MSB aligned |
| sampleValid | output | 1 | One-cycle pulse when a new frame is presented |

## Verification
A wrong bit counter or a mis-set delay shifts every received word by one position, which shows at leftSample and rightSample as a doubled or halved value with one bit lost or a zero bit added, in the very first frame after reset. A wrong channel-tracking state swaps the two words or suppresses the valid pulse, seen one frame-clock change after the right half ends. Faults in the transfer path show as a valid that lasts more than one master clock or samples that move without it, within four master clocks of the right word completing. In master role a wrong divider or half-frame count shows at bclkOut and lrclkOut within the first frame.

// File: rtl/audin_pkg.sv
`timescale 1ns/1ps
package audin_pkg;
  localparam int WORD_W = 24;
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam int MID_W  = WORD_W - 4;
  localparam int LOW_W  = WORD_W - 8;

  localparam logic [1:0] RES_FULL_A = 2'b00;
  localparam logic [1:0] RES_MID    = 2'b01;
  localparam logic [1:0] RES_LOW    = 2'b10;
  localparam logic [1:0] RES_FULL_B = 2'b11;

  typedef struct packed {
    logic             restart;
    logic             loadFirst;
    logic             wrBit;
    logic [CNT_W-1:0] wrPos;
    logic             useNext;
    logic             finLeft;
    logic             finRight;
  } rxStrobe_t;
endpackage

// File: rtl/audin_clkgen.sv
`timescale 1ns/1ps
module audin_clkgen #(
  parameter int DIV_W = 8,
  parameter int HB_W  = 6
) (
  input  logic             mclk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] mclkDiv,
  input  logic [HB_W-1:0]  halfBits,
  output logic             genPhase,
  output logic             genLeft
);
  logic [DIV_W-1:0] divCnt;
  logic [HB_W-1:0]  edgeCnt;
  logic             divHit;

  always_comb divHit = (divCnt == mclkDiv);

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      divCnt   <= '0;
      edgeCnt  <= '0;
      genPhase <= 1'b0;
      genLeft  <= 1'b1;
    end else if (divHit) begin
      divCnt   <= '0;
      genPhase <= ~genPhase;
      if (!genPhase) begin
        // sampling edge of the generated bit clock
        edgeCnt <= edgeCnt + 1'b1;
      end else if (edgeCnt >= halfBits) begin
        // frame clock moves with the non-sampling edge
        edgeCnt <= '0;
        genLeft <= ~genLeft;
      end
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end
endmodule

// File: rtl/audin_ctrl.sv
`timescale 1ns/1ps
module audin_ctrl
  import audin_pkg::*;
(
  input  logic       rxClk,
  input  logic       rst_n,
  input  logic       isLeft,
  input  logic       firstDelay,
  output rxStrobe_t  st
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] TOP  = CNT_W'(WORD_W - 1);

  logic             primed;
  logic             started;
  logic             prevLeft;
  logic [CNT_W-1:0] bitCnt;
  logic             boundary;
  logic             finish;

  always_comb begin
    boundary    = primed && (isLeft != prevLeft);
    finish      = boundary && started;
    st.restart  = boundary;
    st.loadFirst = !firstDelay;
    st.useNext  = firstDelay;
    // with no delay the boundary bit opens the new word instead
    st.wrBit    = (bitCnt < FULL) && !(boundary && !firstDelay);
    st.wrPos    = TOP - bitCnt;
    st.finLeft  = finish && prevLeft;
    st.finRight = finish && !prevLeft;
  end

  always_ff @(posedge rxClk or negedge rst_n) begin
    if (!rst_n) begin
      primed   <= 1'b0;
      started  <= 1'b0;
      prevLeft <= 1'b0;
      bitCnt   <= '0;
    end else begin
      primed   <= 1'b1;
      prevLeft <= isLeft;
      if (boundary) begin
        started <= 1'b1;
        bitCnt  <= firstDelay ? '0 : CNT_W'(1);
      end else if (st.wrBit) begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/audin_data.sv
`timescale 1ns/1ps
module audin_data
  import audin_pkg::*;
(
  input  logic              rxClk,
  input  logic              rst_n,
  input  logic              sdin,
  input  logic              rightJust,
  input  logic [1:0]        resSel,
  input  rxStrobe_t         st,
  output logic [WORD_W-1:0] wordLeft,
  output logic [WORD_W-1:0] wordRight,
  output logic              wordTog
);
  logic [WORD_W-1:0] acc;
  logic [WORD_W-1:0] accNext;
  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] ljWord;
  logic [WORD_W-1:0] rjWord;
  logic [WORD_W-1:0] word;
  logic              haveLeft;

  always_comb begin
    accNext = acc;
    if (st.wrBit) accNext[st.wrPos] = sdin;
    ljWord = st.useNext ? accNext : acc;
    unique case (resSel)
      RES_MID:    rjWord = {shiftReg[MID_W-1:0], {(WORD_W-MID_W){1'b0}}};
      RES_LOW:    rjWord = {shiftReg[LOW_W-1:0], {(WORD_W-LOW_W){1'b0}}};
      RES_FULL_A,
      RES_FULL_B: rjWord = shiftReg;
      default:    rjWord = shiftReg;
    endcase
    word = rightJust ? rjWord : ljWord;
  end

  always_ff @(posedge rxClk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      shiftReg  <= '0;
      wordLeft  <= '0;
      wordRight <= '0;
      wordTog   <= 1'b0;
      haveLeft  <= 1'b0;
    end else begin
      shiftReg <= {shiftReg[WORD_W-2:0], sdin};
      if (st.restart)
        acc <= st.loadFirst ? {sdin, {(WORD_W-1){1'b0}}} : '0;
      else
        acc <= accNext;
      if (st.finLeft) begin
        wordLeft <= word;
        haveLeft <= 1'b1;
      end
      if (st.finRight) begin
        wordRight <= word;
        if (haveLeft) wordTog <= ~wordTog;
      end
    end
  end
endmodule

// File: rtl/audin_xfer.sv
`timescale 1ns/1ps
module audin_xfer #(
  parameter int W = 24
) (
  input  logic         mclk,
  input  logic         rst_n,
  input  logic [W-1:0] wordLeft,
  input  logic [W-1:0] wordRight,
  input  logic         wordTog,
  output logic [W-1:0] leftSample,
  output logic [W-1:0] rightSample,
  output logic         sampleValid
);
  localparam int SYNC_N = 3;
  logic [SYNC_N-1:0] syncQ;
  logic              newFrame;

  always_comb newFrame = syncQ[SYNC_N-1] ^ syncQ[SYNC_N-2];

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      syncQ       <= '0;
      leftSample  <= '0;
      rightSample <= '0;
      sampleValid <= 1'b0;
    end else begin
      syncQ       <= {syncQ[SYNC_N-2:0], wordTog};
      sampleValid <= newFrame;
      if (newFrame) begin
        leftSample  <= wordLeft;
        rightSample <= wordRight;
      end
    end
  end
endmodule

// File: rtl/audin_top.sv
`timescale 1ns/1ps
module audin_top #(
  parameter int DIV_W = 8,
  parameter int HB_W  = 6
) (
  input  logic                          mclk,
  input  logic                          rst_n,
  input  logic                          masterMode,
  input  logic [1:0]                    resSel,
  input  logic                          rightJust,
  input  logic                          firstDelay,
  input  logic                          bclkPol,
  input  logic                          lrPol,
  input  logic [DIV_W-1:0]              mclkDiv,
  input  logic [HB_W-1:0]               halfBits,
  input  logic                          bclkIn,
  input  logic                          lrclkIn,
  input  logic                          sdin,
  output logic                          bclkOut,
  output logic                          lrclkOut,
  output logic [audin_pkg::WORD_W-1:0]  leftSample,
  output logic [audin_pkg::WORD_W-1:0]  rightSample,
  output logic                          sampleValid
);
  import audin_pkg::*;

  logic              genPhase;
  logic              genLeft;
  logic              rxClk;
  logic              isLeftNow;
  rxStrobe_t         strobe;
  logic [WORD_W-1:0] wordLeft;
  logic [WORD_W-1:0] wordRight;
  logic              wordTog;

  audin_clkgen #(.DIV_W(DIV_W), .HB_W(HB_W)) u_clkgen (
    .mclk(mclk), .rst_n(rst_n), .mclkDiv(mclkDiv), .halfBits(halfBits),
    .genPhase(genPhase), .genLeft(genLeft)
  );

  // receive clock: rising edge is always the sampling edge
  always_comb begin
    rxClk     = masterMode ? genPhase : (bclkIn ^ bclkPol);
    isLeftNow = masterMode ? genLeft  : (lrclkIn ^ lrPol);
    bclkOut   = masterMode & (genPhase ^ bclkPol);
    lrclkOut  = masterMode & (genLeft ^ lrPol);
  end

  audin_ctrl u_ctrl (
    .rxClk(rxClk), .rst_n(rst_n), .isLeft(isLeftNow),
    .firstDelay(firstDelay), .st(strobe)
  );

  audin_data u_data (
    .rxClk(rxClk), .rst_n(rst_n), .sdin(sdin), .rightJust(rightJust),
    .resSel(resSel), .st(strobe), .wordLeft(wordLeft),
    .wordRight(wordRight), .wordTog(wordTog)
  );

  audin_xfer #(.W(WORD_W)) u_xfer (
    .mclk(mclk), .rst_n(rst_n), .wordLeft(wordLeft), .wordRight(wordRight),
    .wordTog(wordTog), .leftSample(leftSample), .rightSample(rightSample),
    .sampleValid(sampleValid)
  );
endmodule

// File: rtl/audin_checker.sv
`timescale 1ns/1ps
module audin_checker #(
  parameter int DIV_W = 8,
  parameter int W     = 24
) (
  input logic             mclk,
  input logic             rst_n,
  input logic             masterMode,
  input logic             bclkPol,
  input logic             lrPol,
  input logic [DIV_W-1:0] mclkDiv,
  input logic             bclkOut,
  input logic             lrclkOut,
  input logic [W-1:0]     leftSample,
  input logic [W-1:0]     rightSample,
  input logic             sampleValid
);
  a_r7_single_pulse: assert property (@(posedge mclk) disable iff (!rst_n)
    sampleValid |=> !sampleValid);

  a_r7_left_hold: assert property (@(posedge mclk) disable iff (!rst_n)
    !sampleValid |-> $stable(leftSample));

  a_r7_right_hold: assert property (@(posedge mclk) disable iff (!rst_n)
    !sampleValid |-> $stable(rightSample));

  a_r9_frame_on_idle_edge: assert property (@(posedge mclk) disable iff (!rst_n)
    (masterMode && $past(masterMode) && $stable(bclkPol) && $stable(lrPol)
     && !$stable(lrclkOut)) |-> (bclkOut == bclkPol));

  a_r9_bit_clock_width: assert property (@(posedge mclk) disable iff (!rst_n)
    (masterMode && $past(masterMode) && mclkDiv != '0 && $stable(mclkDiv)
     && $stable(bclkPol) && !$stable(bclkOut)) |=> $stable(bclkOut));

  a_r10_slave_quiet: assert property (@(posedge mclk) disable iff (!rst_n)
    !masterMode |-> (!bclkOut && !lrclkOut));
endmodule

bind audin_top audin_checker #(.DIV_W(DIV_W), .W(audin_pkg::WORD_W)) u_chk (
  .mclk(mclk), .rst_n(rst_n), .masterMode(masterMode), .bclkPol(bclkPol),
  .lrPol(lrPol), .mclkDiv(mclkDiv), .bclkOut(bclkOut), .lrclkOut(lrclkOut),
  .leftSample(leftSample), .rightSample(rightSample), .sampleValid(sampleValid)
);

// File: tb/sim_audin_top.sv
`timescale 1ns/1ps
module sim_audin_top;
  logic        mclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        masterMode = 1'b0;
  logic [1:0]  resSel = 2'b00;
  logic        rightJust = 1'b0;
  logic        firstDelay = 1'b0;
  logic        bclkPol = 1'b0;
  logic        lrPol = 1'b0;
  logic [7:0]  mclkDiv = 8'd2;
  logic [5:0]  halfBits = 6'd8;
  logic        bclkIn = 1'b0;
  logic        lrclkIn = 1'b0;
  logic        sdin = 1'b0;
  logic        bclkOut, lrclkOut, sampleValid;
  logic [23:0] leftSample, rightSample;

  int total = 0;
  int fails = 0;
  int vcnt = 0;
  logic [23:0] capL = '0, capR = '0;
  bit done = 1'b0;

  always #4 mclk = ~mclk;

  audin_top u0 (
    .mclk(mclk), .rst_n(rst_n), .masterMode(masterMode), .resSel(resSel),
    .rightJust(rightJust), .firstDelay(firstDelay), .bclkPol(bclkPol),
    .lrPol(lrPol), .mclkDiv(mclkDiv), .halfBits(halfBits), .bclkIn(bclkIn),
    .lrclkIn(lrclkIn), .sdin(sdin), .bclkOut(bclkOut), .lrclkOut(lrclkOut),
    .leftSample(leftSample), .rightSample(rightSample), .sampleValid(sampleValid)
  );

  always @(negedge mclk) begin
    if (sampleValid) begin
      vcnt = vcnt + 1;
      capL = leftSample;
      capR = rightSample;
    end
  end

  typedef struct packed {
    logic        rj;
    logic        dly;
    logic        bpol;
    logic        lpol;
    logic [1:0]  res;
    logic [5:0]  slots;
    logic [5:0]  len;
    logic [31:0] lw;
    logic [31:0] rw;
    logic [23:0] el;
    logic [23:0] er;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,2'b00,6'd32,6'd24,32'h00A5C3F1,32'h00123456,24'hA5C3F1,24'h123456},
    '{1'b0,1'b1,1'b0,1'b1,2'b00,6'd32,6'd24,32'h006B2E9D,32'h00F00F81,24'h6B2E9D,24'hF00F81},
    '{1'b0,1'b0,1'b0,1'b0,2'b00,6'd16,6'd16,32'h0000BEEF,32'h00001234,24'hBEEF00,24'h123400},
    '{1'b0,1'b0,1'b0,1'b0,2'b00,6'd32,6'd32,32'hDEADBEEF,32'h0F1E2D3C,24'hDEADBE,24'h0F1E2D},
    '{1'b1,1'b0,1'b0,1'b0,2'b10,6'd32,6'd16,32'h0000CAFE,32'h00000101,24'hCAFE00,24'h010100},
    '{1'b1,1'b0,1'b0,1'b0,2'b01,6'd32,6'd20,32'h000ABCDE,32'h00013579,24'hABCDE0,24'h135790},
    '{1'b1,1'b0,1'b0,1'b0,2'b00,6'd32,6'd24,32'h0089ABCD,32'h00765432,24'h89ABCD,24'h765432},
    '{1'b0,1'b0,1'b1,1'b0,2'b00,6'd32,6'd24,32'h003C3C3C,32'h00C3C3C3,24'h3C3C3C,24'hC3C3C3},
    '{1'b0,1'b1,1'b0,1'b1,2'b00,6'd24,6'd20,32'h000FEDCB,32'h00000001,24'hFEDCB0,24'h000010},
    '{1'b1,1'b0,1'b1,1'b0,2'b11,6'd32,6'd24,32'h00555AAA,32'h00AAA555,24'h555AAA,24'hAAA555}
  };

  function automatic string tagOf(vec_t v);
    if (v.bpol && v.rj) return "R5 R6";
    if (v.bpol)         return "R6";
    if (v.rj)           return "R5";
    if (v.dly)          return "R4";
    if (v.len > 6'd24)  return "R3";
    return "R2";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge mclk);
    rst_n = 1'b1;
    repeat (2) @(negedge mclk);
  endtask

  // one bit slot: non-sampling level first, then the sampling edge
  task automatic drive_slot(input logic left, input logic b);
    bclkIn  = bclkPol;
    lrclkIn = left ^ lrPol;
    sdin    = b;
    #20;
    bclkIn  = ~bclkPol;
    #20;
  endtask

  task automatic send_half(input logic left, input logic [31:0] w, input int len,
                           input int slots, input logic rj, input logic dly);
    for (int j = 0; j < slots; j++) begin
      logic b;
      int k;
      if (rj) begin
        k = j - (slots - len);
        b = (k >= 0) ? w[len-1-k] : 1'b1;
      end else begin
        k = j - int'(dly);
        b = (k >= 0 && k < len) ? w[len-1-k] : 1'b0;
      end
      drive_slot(left, b);
    end
  endtask

  initial begin
    repeat (200000) @(posedge mclk);
    if (!done) begin
      total = total + 1;
      fails = fails + 1;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    bit inLr;
    int rises, firstRise, secondRise, cyc;
    logic prevB;

    // R1: reset state
    rst_n = 1'b0;
    repeat (3) @(negedge mclk);
    check("R1 left during reset", {8'h0, leftSample}, 32'h0);
    check("R1 valid during reset", {31'h0, sampleValid}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge mclk);
    check("R1 right after reset", {8'h0, rightSample}, 32'h0);
    check("R1 valid after reset", {31'h0, sampleValid}, 32'h0);

    // table of formats in slave role
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      rightJust  = v.rj;
      firstDelay = v.dly;
      bclkPol    = v.bpol;
      lrPol      = v.lpol;
      resSel     = v.res;
      bclkIn     = v.bpol;
      do_reset();
      vcnt = 0;
      drive_slot(1'b0, 1'b0);
      drive_slot(1'b0, 1'b0);
      send_half(1'b1, v.lw, int'(v.len), int'(v.slots), v.rj, v.dly);
      send_half(1'b0, v.rw, int'(v.len), int'(v.slots), v.rj, v.dly);
      drive_slot(1'b1, 1'b0);
      repeat (20) @(negedge mclk);
      check({"R7 pulse count ", tagOf(v)}, vcnt, 1);
      check({tagOf(v), " left"}, {8'h0, capL}, {8'h0, v.el});
      check({tagOf(v), " right"}, {8'h0, capR}, {8'h0, v.er});
      check("R10 slave outputs", {30'h0, bclkOut, lrclkOut}, 32'h0);
    end

    // R8: no valid from a frame without a left word that began after a boundary
    rightJust = 1'b0; firstDelay = 1'b0; bclkPol = 1'b0; lrPol = 1'b0; resSel = 2'b00;
    bclkIn = 1'b0;
    do_reset();
    vcnt = 0;
    send_half(1'b1, 32'h00ABCDEF, 24, 32, 1'b0, 1'b0);
    send_half(1'b0, 32'h00FEDCBA, 24, 32, 1'b0, 1'b0);
    drive_slot(1'b1, 1'b0);
    repeat (20) @(negedge mclk);
    check("R8 no early valid", vcnt, 0);
    check("R8 left still reset", {8'h0, leftSample}, 32'h0);

    // R9: master role clock generation
    masterMode = 1'b1; mclkDiv = 8'd2; halfBits = 6'd8;
    do_reset();
    @(posedge lrclkOut);
    @(negedge mclk);
    rises = 0; firstRise = -1; secondRise = -1; cyc = 0;
    prevB = bclkOut;
    inLr = 1'b1;
    while (inLr && cyc < 2000) begin
      @(negedge mclk);
      cyc = cyc + 1;
      if (bclkOut && !prevB) begin
        if (firstRise < 0) firstRise = cyc;
        else if (secondRise < 0) secondRise = cyc;
        rises = rises + 1;
      end
      prevB = bclkOut;
      if (!lrclkOut) begin
        inLr = 1'b0;
        check("R9 bit clock idle at frame change", {31'h0, bclkOut}, 32'h0);
      end
    end
    check("R9 sampling edges per half", rises, 8);
    check("R9 bit clock period", secondRise - firstRise, 6);
    masterMode = 1'b0;
    @(negedge mclk);
    check("R10 outputs after leaving master", {30'h0, bclkOut, lrclkOut}, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule